// File: doc/BRIEF.md
# One-Wire Time-Base Divider

This block turns the system clock into a 1 MHz enable tick that paces a one-wire bus master. The host works out a 5-bit divider value from the system clock frequency and writes it with a single-cycle write strobe. The block splits that value into two fields, an odd prescaler and a power-of-two stage. Their product is the division ratio, so a whole range of clock rates can reach the same 1 MHz tick.

Every write restarts the divider phase and clears a stable flag. The flag rises again after a fixed number of ticks. The bus master waits for this flag before it issues a bus reset, which gives the time base a settling period. Writing zero parks the block: no ticks are produced and the flag stays low.

Top module: `onewire_timebase`

## Requirements
- R1: After a synchronous reset, `tick` and `stable` are 0 and the divider value is 0, so no tick appears until a nonzero value is written.
- R2: The divider value is split into two fields. Bits [1:0] = c select a prescale of 2c+1, giving 1, 3, 5 or 7. Bits [4:2] = n select a divide by 2^n. The ratio R is (2c+1)·2^n. As examples, 0x08 gives 4, 0x02 gives 5, 0x05 gives 6, 0x03 gives 7, 0x06 gives 10, 0x10 gives 16 and 0x1C gives 128.
- R3: `tick` is high for one cycle out of every R. After a write takes effect at clock edge E0, the first tick is high in the cycle that follows edge E0+R, and the next ones follow every R edges after that.
- R4: While the divider value is 0, `tick` stays low and `stable` stays low.
- R5: `stable` rises at the same edge as the 16th tick after a write, and it stays high until the next write or reset.
- R6: A write clears `tick` and `stable` at its own edge and restarts the divider phase from zero, whatever the previous value was.
- R7: `div_wdata` is ignored while `div_we` is low, so the tick period keeps the last written ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Single-cycle write strobe for the divider value |
| div_wdata | input | 5 | New divider value: prescale code in [1:0], exponent in [4:2] |
| tick | output | 1 | One-cycle enable pulse at the divided rate |
| stable | output | 1 | High once 16 ticks have elapsed since the last write |

## Verification
The assertions assume that writes are single-cycle pulses of `div_we`. They also assume that a nonzero value is never smaller than ratio 2, which holds because the value 0 is the only code with ratio 1 and it parks the block. The stimulus writes only whole values: seven frequency examples, zero, and random nonzero values. Between writes it holds `div_we` low for at least three full tick periods while it drives random garbage on `div_wdata`, so a stray write would show up as a wrong period.

// File: rtl/owtb_pkg.sv
package owtb_pkg;
  // Settling ticks required after a divider write before the flag rises.
  localparam int unsigned SETTLE_TICKS = 16;

  // Odd prescale chosen by the low field: code c -> 2c+1.
  function automatic int unsigned odd_prescale(input int unsigned code);
    return 2 * code + 1;
  endfunction
endpackage

// File: rtl/owtb_prescaler.sv
module owtb_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] code,
  output logic             pulse
);
  localparam int PC_W = PRE_W + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last;

  // Counting 0..2c gives a period of 2c+1 cycles.
  assign last  = {code, 1'b0};
  assign pulse = run && (pc == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pc <= '0;
    end else if (run) begin
      pc <= pulse ? '0 : pc + PC_W'(1);
    end
  end
endmodule

// File: rtl/owtb_pow2.sv
module owtb_pow2 #(
  parameter int POW_W = 3,
  parameter int Q_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             in_pulse,
  input  logic [POW_W-1:0] expo,
  output logic             out_pulse
);
  logic [Q_W-1:0] qc;
  logic [Q_W-1:0] mask;

  // Mask of the low expo bits; a full mask marks the last of 2^expo pulses.
  for (genvar gi = 0; gi < Q_W; gi++) begin : g_mask
    assign mask[gi] = (expo > POW_W'(gi));
  end

  assign out_pulse = in_pulse && ((qc & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      qc <= '0;
    end else if (in_pulse) begin
      qc <= qc + Q_W'(1);
    end
  end
endmodule

// File: rtl/owtb_settle.sv
module owtb_settle #(
  parameter int COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick_next,
  output logic stable
);
  localparam int CW = $clog2(COUNT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (tick_next && (cnt != CW'(COUNT))) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(COUNT - 1)) begin
        stable <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/onewire_timebase.sv
module onewire_timebase #(
  parameter int DIV_W  = 5,
  parameter int PRE_W  = 2,
  parameter int SETTLE = owtb_pkg::SETTLE_TICKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             tick,
  output logic             stable
);
  localparam int POW_W = DIV_W - PRE_W;
  localparam int Q_W   = (1 << POW_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic             run;
  logic             pre_pulse;
  logic             stage_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (div_we) begin
      div_q <= div_wdata;
    end
  end

  assign run = (div_q != '0);

  owtb_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (div_we),
    .run     (run),
    .code    (div_q[PRE_W-1:0]),
    .pulse   (pre_pulse)
  );

  owtb_pow2 #(.POW_W(POW_W), .Q_W(Q_W)) u_pow (
    .clk       (clk),
    .rst       (rst),
    .restart   (div_we),
    .in_pulse  (pre_pulse),
    .expo      (div_q[DIV_W-1:PRE_W]),
    .out_pulse (stage_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst || div_we) begin
      tick <= 1'b0;
    end else begin
      tick <= stage_pulse;
    end
  end

  owtb_settle #(.COUNT(SETTLE)) u_settle (
    .clk       (clk),
    .rst       (rst),
    .restart   (div_we),
    .tick_next (stage_pulse),
    .stable    (stable)
  );
endmodule

// File: rtl/onewire_timebase_chk.sv
module onewire_timebase_chk #(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             div_we,
  input logic [DIV_W-1:0] div_wdata,
  input logic             tick,
  input logic             stable
);
  // Smallest active ratio is 2, so a tick is never followed by another one.
  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (div_we && div_wdata == '0) |=> (!tick && !stable));

  p_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
    div_we |=> (!tick && !stable));

  p_stable_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stable && !div_we) |=> stable);

  p_stable_with_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stable) |-> tick);
endmodule

bind onewire_timebase onewire_timebase_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .div_we    (div_we),
  .div_wdata (div_wdata),
  .tick      (tick),
  .stable    (stable)
);

// File: tb/onewire_timebase_tb.sv
module onewire_timebase_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       div_we;
  logic [4:0] div_wdata;
  logic       tick;
  logic       stable;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  onewire_timebase u_dut (
    .clk       (clk),
    .rst       (rst),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .tick      (tick),
    .stable    (stable)
  );

  function automatic int exp_ratio(input logic [4:0] v);
    return (2 * int'(v[1:0]) + 1) << v[4:2];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic do_write(input logic [4:0] v);
    @(negedge clk);
    div_we    = 1'b1;
    div_wdata = v;
    @(negedge clk);
    div_we    = 1'b0;
  endtask

  // Writes v, then checks the tick pattern (R2, R3, R7) and optionally the
  // stable flag (R5) cycle by cycle after the write edge.
  task automatic run_value(input logic [4:0] v, input bit with_stable);
    int r       = exp_ratio(v);
    int span    = with_stable ? 16 * r + 3 : 3 * r;
    int t_bad   = 0;
    int s_bad   = 0;
    int first_t = -1;
    do_write(v);
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      div_wdata = 5'($urandom);
      if (tick !== ((k % r) == 0)) t_bad++;
      if (tick === 1'b1 && first_t < 0) first_t = k;
      if (stable !== (k >= 16 * r)) s_bad++;
    end
    check(t_bad == 0, "R2/R3/R7", $sformatf("tick pattern v=%0h", v), t_bad, 0);
    check(first_t == r, "R3", $sformatf("first tick v=%0h", v), first_t, r);
    if (with_stable)
      check(s_bad == 0, "R5", $sformatf("stable timing v=%0h", v), s_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c));
    rst = 1'b1; div_we = 1'b0; div_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tick === 1'b0 && stable === 1'b0, "R1", "reset outputs",
          {tick, stable}, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        div_wdata = 5'($urandom);
        if (tick !== 1'b0 || stable !== 1'b0) seen++;
      end
      check(seen == 0, "R1", "idle after reset", seen, 0);
    end

    // Directed frequency examples (R2).
    run_value(5'h08, 1'b1);
    run_value(5'h02, 1'b1);
    run_value(5'h05, 1'b0);
    run_value(5'h03, 1'b0);
    run_value(5'h06, 1'b0);
    run_value(5'h10, 1'b0);
    run_value(5'h1C, 1'b1);

    // Rewrite while stable (R6): stable and tick low right after the write.
    do_write(5'h04);
    check(stable === 1'b0 && tick === 1'b0, "R6", "clear on rewrite",
          {tick, stable}, 0);
    begin
      int first_t = -1;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (tick === 1'b1 && first_t < 0) first_t = k;
      end
      check(first_t == 2, "R6", "phase restart", first_t, 2);
    end

    // Zero parks the block (R4).
    run_value(5'h01, 1'b1);
    do_write(5'h00);
    begin
      int seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        div_wdata = 5'($urandom);
        if (tick !== 1'b0 || stable !== 1'b0) seen++;
      end
      check(seen == 0, "R4", "zero value idle", seen, 0);
    end

    // Random nonzero values.
    for (int i = 0; i < 20; i++) begin
      logic [4:0] v;
      v = 5'($urandom_range(1, 31));
      run_value(v, 1'b0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule